// File: doc/BRIEF.md
# Wavetable Audio Channel

This block is one voice of a sound generator. It plays back a user-loaded waveform of thirty-two 4-bit samples kept in a 16-byte sample RAM. A period counter, clocked by the channel tick, sets the pitch. Each time the counter expires, the sequencer steps to the next sample and latches it. A 2-bit volume code scales the latched sample by a right shift, and the result is the 4-bit output.

Software programs the voice through a byte-wide register port: five control registers and the sample RAM window. A length counter, stepped by an external length clock, can stop the voice after a programmed time. The voice also stops when its DAC is switched off. Reading a register returns its stored fields with every unused bit forced to one.

Address map (5-bit address): 0x00 DAC control, 0x01 length, 0x02 volume, 0x03 frequency low, 0x04 trigger/control, 0x05-0x0F unmapped, 0x10-0x1F sample RAM bytes 0-15.

Top module: `wave_voice`

## Requirements
- R1: Sample RAM byte i is at address 0x10+i. It is written and read back at once through the register port. Sample index k (0-31) uses byte k/2: the high nibble when k is even and the low nibble when k is odd.
- R2: On each channel tick, a nonzero period counter decrements. When it would reach zero, it reloads with 2048 minus the 11-bit frequency. The 5-bit sample offset advances by one, wrapping from 31 to 0, and the sample at the new offset is latched.
- R3: The volume code in bits 6:5 of address 0x02 shifts the latched sample right. Code 0 mutes the output, 1 shifts by 0, 2 shifts by 1 and 3 shifts by 2. A change takes effect on the cycle after the write.
- R4: The output is 0 whenever the voice is not enabled.
- R5: Bit 7 of address 0x00 is the DAC enable. Writing it as 0 disables the voice. A trigger enables the voice only when the DAC enable is 1.
- R6: A write to address 0x01 loads the whole 8-bit length counter. When the length enable is set, each length clock increments the counter, and a wrap from 0xFF to 0 disables the voice. When the length enable is clear, length clocks have no effect.
- R7: A write to address 0x04 sets the high three frequency bits from bits 2:0 and the length enable from bit 6. When bit 7 is also set, the write triggers the voice: the offset goes to 0, the period reloads from the new frequency, and the latched sample is kept.
- R8: Read-back: 0x00 returns dac<<7|0x7F; 0x02 returns 0x80|vol<<5|0x1F; 0x04 returns 0x80|len_en<<6|0x3F; 0x01, 0x03 and 0x05-0x0F return 0xFF.
- R9: Reset clears the enable, DAC enable, volume, frequency, length enable, length counter, period, offset and latched sample. Reset leaves the sample RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register / sample RAM address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from reg_addr) |
| ch_tick | input | 1 | Channel tick, one-cycle pulse, steps the period counter |
| len_tick | input | 1 | Length clock, one-cycle pulse |
| voice_out | output | 4 | Scaled sample output |

## Verification
The bench sets the highest frequency so that the offset steps on every tick, and plays all 32 samples through the wrap back to index 0. A design with swapped nibble order or a stuck offset bit would play a visibly wrong sequence. A reload of 3 ticks separates a correct period from an off-by-one. An off-by-one period would step one tick early or late.

The length counter is loaded at 0xFD. A correct voice stops on the third length clock; a design that compares at the wrong value would stop too early or too late. The bench also checks that the voice keeps playing when the length enable is clear. It checks that a trigger with the DAC off leaves the output silent, and that sample RAM survives a reset that clears every control field.

// File: rtl/wv_pkg.sv
package wv_pkg;

  // control register slots inside the low half of the address space
  typedef enum logic [2:0] {
    SLOT_DAC  = 3'd0,
    SLOT_LEN  = 3'd1,
    SLOT_VOL  = 3'd2,
    SLOT_FLO  = 3'd3,
    SLOT_CTL  = 3'd4
  } wv_slot_e;

  // volume code to attenuated sample
  function automatic logic [3:0] wv_scale(input logic [3:0] smp, input logic [1:0] code);
    logic [3:0] r;
    case (code)
      2'd0:    r = 4'd0;
      2'd1:    r = smp;
      2'd2:    r = smp >> 1;
      default: r = smp >> 2;
    endcase
    return r;
  endfunction

  // pick a nibble of a RAM byte: even index -> upper half
  function automatic logic [3:0] wv_pick(input logic [7:0] b, input logic odd);
    return odd ? b[3:0] : b[7:4];
  endfunction

endpackage

// File: rtl/wv_regs.sv
module wv_regs
  import wv_pkg::*;
#(
  parameter int FREQ_W    = 11,
  parameter int RAM_BYTES = 16,
  localparam int RAM_AW   = $clog2(RAM_BYTES),
  localparam int ADDR_W   = RAM_AW + 1,
  localparam int HI_W     = FREQ_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  // decoded fields
  output logic              dac_en,
  output logic [1:0]        vol,
  output logic [FREQ_W-1:0] freq,
  output logic              len_en,
  // write events
  output logic              trig,
  output logic [FREQ_W-1:0] trig_freq,
  output logic              len_load,
  output logic              dac_kill,
  // sequencer read port
  input  logic [ADDR_W-1:0] smp_idx,
  output logic [3:0]        smp_nib
);

  logic [7:0] ram [RAM_BYTES];

  logic              ram_sel;
  logic              ctl_sel;
  logic [2:0]        slot;
  logic [7:0]        flo_q;
  logic [HI_W-1:0]   fhi_q;

  assign ram_sel = addr[ADDR_W-1];
  assign slot    = addr[2:0];
  assign ctl_sel = !ram_sel && (addr[ADDR_W-2:3] == '0);

  logic wr_dac, wr_len, wr_vol, wr_flo, wr_ctl;
  assign wr_dac = wr_en && ctl_sel && (slot == SLOT_DAC);
  assign wr_len = wr_en && ctl_sel && (slot == SLOT_LEN);
  assign wr_vol = wr_en && ctl_sel && (slot == SLOT_VOL);
  assign wr_flo = wr_en && ctl_sel && (slot == SLOT_FLO);
  assign wr_ctl = wr_en && ctl_sel && (slot == SLOT_CTL);

  assign trig      = wr_ctl && wdata[7];
  assign trig_freq = {wdata[HI_W-1:0], flo_q};
  assign len_load  = wr_len;
  assign dac_kill  = wr_dac && !wdata[7];
  assign freq      = {fhi_q, flo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_en <= 1'b0;
      vol    <= 2'd0;
      flo_q  <= 8'd0;
      fhi_q  <= '0;
      len_en <= 1'b0;
    end else begin
      if (wr_dac) dac_en <= wdata[7];
      if (wr_vol) vol    <= wdata[6:5];
      if (wr_flo) flo_q  <= wdata;
      if (wr_ctl) begin
        fhi_q  <= wdata[HI_W-1:0];
        len_en <= wdata[6];
      end
    end
  end

  // sample storage: kept across reset
  always_ff @(posedge clk) begin
    if (wr_en && ram_sel) ram[addr[RAM_AW-1:0]] <= wdata;
  end

  assign smp_nib = wv_pick(ram[smp_idx[ADDR_W-1:1]], smp_idx[0]);

  always_comb begin
    rdata = 8'hFF;
    if (ram_sel) begin
      rdata = ram[addr[RAM_AW-1:0]];
    end else if (ctl_sel) begin
      case (slot)
        SLOT_DAC: rdata = {dac_en, 7'h7F};
        SLOT_VOL: rdata = {1'b1, vol, 5'h1F};
        SLOT_CTL: rdata = {1'b1, len_en, 6'h3F};
        default:  rdata = 8'hFF;
      endcase
    end
  end

  AST_DAC_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dac |=> dac_en == $past(wdata[7])); // R5

endmodule

// File: rtl/wv_seq.sv
module wv_seq #(
  parameter int FREQ_W = 11,
  parameter int OFF_W  = 5,
  localparam int PER_W = FREQ_W + 1,
  localparam logic [PER_W-1:0] SPAN = PER_W'(1) << FREQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              trig,
  input  logic [FREQ_W-1:0] trig_freq,
  input  logic [FREQ_W-1:0] freq,
  input  logic [3:0]        nib_in,
  output logic [OFF_W-1:0]  next_off,
  output logic [3:0]        sample,
  output logic              step
);

  logic [PER_W-1:0] per_q;
  logic [OFF_W-1:0] off_q;

  function automatic logic [PER_W-1:0] reload_of(input logic [FREQ_W-1:0] f);
    return SPAN - {1'b0, f};
  endfunction

  assign next_off = off_q + 1'b1;
  assign step     = tick && !trig && (per_q == PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      off_q  <= '0;
      sample <= 4'd0;
    end else if (trig) begin
      per_q <= reload_of(trig_freq);
      off_q <= '0;
    end else if (tick && per_q != '0) begin
      if (step) begin
        per_q  <= reload_of(freq);
        off_q  <= next_off;
        sample <= nib_in;
      end else begin
        per_q <= per_q - 1'b1;
      end
    end
  end

  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> off_q == OFF_W'($past(off_q) + 1'b1)); // R2
  AST_PER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    per_q <= SPAN); // R2
  AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (off_q == '0) && (per_q == SPAN - {1'b0, $past(trig_freq)})); // R7
  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !trig |=> per_q == $past(per_q)); // R2

endmodule

// File: rtl/wv_len.sv
module wv_len #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             len_clk,
  input  logic             len_en,
  output logic             expire
);

  logic [LEN_W-1:0] len_q;
  logic             bump;

  assign bump   = len_clk && len_en && !load;
  assign expire = bump && (len_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n)     len_q <= '0;
    else if (load)  len_q <= load_val;
    else if (bump)  len_q <= len_q + 1'b1;
  end

  AST_LEN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> len_q == '0); // R6
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !(len_clk && len_en) |=> len_q == $past(len_q)); // R6

endmodule

// File: rtl/wave_voice.sv
module wave_voice
  import wv_pkg::*;
#(
  parameter int FREQ_W    = 11,
  parameter int RAM_BYTES = 16,
  parameter int LEN_W     = 8,
  localparam int ADDR_W   = $clog2(RAM_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ch_tick,
  input  logic              len_tick,
  output logic [3:0]        voice_out
);

  logic              dac_en, len_en, trig, len_load, dac_kill, expire, step;
  logic [1:0]        vol;
  logic [FREQ_W-1:0] freq, trig_freq;
  logic [ADDR_W-1:0] next_off;
  logic [3:0]        nib, sample;
  logic              en_q;

  wv_regs #(.FREQ_W(FREQ_W), .RAM_BYTES(RAM_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .dac_en(dac_en), .vol(vol),
    .freq(freq), .len_en(len_en), .trig(trig), .trig_freq(trig_freq),
    .len_load(len_load), .dac_kill(dac_kill), .smp_idx(next_off),
    .smp_nib(nib)
  );

  wv_seq #(.FREQ_W(FREQ_W), .OFF_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(ch_tick), .trig(trig),
    .trig_freq(trig_freq), .freq(freq), .nib_in(nib),
    .next_off(next_off), .sample(sample), .step(step)
  );

  wv_len #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .load(len_load),
    .load_val(reg_wdata[LEN_W-1:0]), .len_clk(len_tick),
    .len_en(len_en), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (dac_kill) en_q <= 1'b0;
    else if (trig)     en_q <= dac_en;
    else if (expire)   en_q <= 1'b0;
  end

  assign voice_out = en_q ? wv_scale(sample, vol) : 4'd0;

  AST_DAC_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    dac_kill |=> !en_q); // R5
  AST_LEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !trig |=> !en_q); // R6
  AST_TRIG_EN: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> en_q == $past(dac_en)); // R7
  AST_STEP_ON: assert property (@(posedge clk) disable iff (!rst_n)
    step && !dac_kill && !expire |=> en_q == $past(en_q)); // R2

endmodule

// File: tb/wave_voice_tb.sv
`timescale 1ns/1ps
module wave_voice_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = 5'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ch_tick = 1'b0;
  logic       len_tick = 1'b0;
  logic [3:0] voice_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wave_voice u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_tick(ch_tick),
    .len_tick(len_tick), .voice_out(voice_out)
  );

  function automatic logic [3:0] nib(input int k);
    return 4'((k % 15) + 1);
  endfunction

  function automatic logic [7:0] ram_byte(input int i);
    return {nib(2*i), nib(2*i+1)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ch_tick = 1'b1;
      @(negedge clk); ch_tick = 1'b0;
    end
  endtask

  task automatic lclks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); len_tick = 1'b1;
      @(negedge clk); len_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R4 out after reset", voice_out, 0);
    rd_chk("R9 dac field reset", 5'h00, 8'h7F);
    rd_chk("R8 length reads ones", 5'h01, 8'hFF);
    rd_chk("R9 volume reset", 5'h02, 8'h9F);
    rd_chk("R8 freq low reads ones", 5'h03, 8'hFF);
    rd_chk("R9 ctl reset", 5'h04, 8'hBF);
    rd_chk("R8 unmapped", 5'h09, 8'hFF);
  endtask

  task automatic t_ram;
    for (int i = 0; i < 16; i++) wr(5'(16 + i), ram_byte(i));
    for (int i = 0; i < 16; i++) rd_chk("R1 ram readback", 5'(16 + i), ram_byte(i));
  endtask

  task automatic t_play;
    wr(5'h00, 8'h80);
    wr(5'h02, 8'h20);
    wr(5'h03, 8'hFF);
    wr(5'h04, 8'h87);
    chk("R7 trigger keeps latch", voice_out, 0);
    for (int k = 1; k <= 33; k++) begin
      ticks(1);
      chk("R2 R1 sample sequence", voice_out, nib(k % 32));
    end
  endtask

  task automatic t_period;
    wr(5'h03, 8'hFD);
    wr(5'h04, 8'h87);
    ticks(5);
    chk("R2 period 3 after 5 ticks", voice_out, nib(1));
    ticks(1);
    chk("R2 period 3 after 6 ticks", voice_out, nib(2));
  endtask

  task automatic t_volume;
    wr(5'h03, 8'hFF);
    wr(5'h04, 8'h87);
    ticks(14);
    chk("R3 code1 full", voice_out, 15);
    wr(5'h02, 8'h00);
    chk("R3 code0 mute", voice_out, 0);
    wr(5'h02, 8'h40);
    chk("R3 code2 half", voice_out, 7);
    rd_chk("R8 volume readback", 5'h02, 8'hDF);
    wr(5'h02, 8'h60);
    chk("R3 code3 quarter", voice_out, 3);
    wr(5'h02, 8'h20);
  endtask

  task automatic t_length;
    wr(5'h01, 8'hFD);
    wr(5'h04, 8'hC7);
    chk("R6 on after trigger", voice_out, 15);
    rd_chk("R8 ctl len_en", 5'h04, 8'hFF);
    lclks(2);
    chk("R6 still on at 0xFF", voice_out, 15);
    lclks(1);
    chk("R6 off at wrap", voice_out, 0);
    wr(5'h01, 8'hFF);
    wr(5'h04, 8'h87);
    lclks(3);
    chk("R6 len clock ignored", voice_out, 15);
    rd_chk("R8 ctl no len_en", 5'h04, 8'hBF);
  endtask

  task automatic t_dac;
    wr(5'h00, 8'h00);
    chk("R5 dac off silences", voice_out, 0);
    rd_chk("R8 dac readback", 5'h00, 8'h7F);
    wr(5'h04, 8'h87);
    chk("R5 trigger with dac off", voice_out, 0);
    wr(5'h00, 8'h80);
    chk("R4 dac on alone stays off", voice_out, 0);
    rd_chk("R8 dac readback on", 5'h00, 8'hFF);
    wr(5'h04, 8'h87);
    chk("R5 trigger with dac on", voice_out, 15);
  endtask

  task automatic t_reset_ram;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    chk("R9 out cleared", voice_out, 0);
    rd_chk("R9 ram kept", 5'h13, ram_byte(3));
    rd_chk("R9 ram kept last", 5'h1F, ram_byte(15));
    rd_chk("R9 vol cleared", 5'h02, 8'h9F);
    rd_chk("R9 dac cleared", 5'h00, 8'h7F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ram;
    t_play;
    t_period;
    t_volume;
    t_length;
    t_dac;
    t_reset_ram;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule